// File: doc/BRIEF.md
# Card Clock Generator with FIFO Stall

This block derives the clock that drives a memory card from the controller's master clock. A small mode register sets the division ratio. The ratio comes from an 8-bit coarse field and a separate parity bit, so odd and even ratios are both available, and the duty cycle stays as close to half as an integer count allows. An input requests power saving. While it is high, the period is stretched by a further factor chosen by a 3-bit field.

During a data transfer the clock can be frozen low. This keeps the host FIFO from overflowing on reads and from running dry on writes. Each kind of freeze has its own enable bit and follows a transfer-direction input. The block changes the clock only at the end of a low phase, so the card never sees a shortened pulse. A one-cycle strobe marks each rising edge of the card clock, which lets neighbouring logic stay entirely in the master clock domain. A lock register guards the mode register against accidental writes.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, the mode register and the lock bit read zero and the card clock is low. The first rising-edge strobe appears one master cycle after reset is released, and the clock then runs at a period of 2.
- R2: With power saving off, the card clock period N, measured between rising-edge strobes, is 2·D + P + 2 master cycles. D is mode bits [7:0] and P is mode bit [8].
- R3: For each period M, the high phase lasts floor(M/2) master cycles and the low phase lasts ceil(M/2) master cycles.
- R4: With the pwr_save input high, the period M is N·(2^S + 1), where S is mode bits [11:9].
- R5: When mode bit [12] is set, xfer_active is high, xfer_rd is 1 and fifo_full is high, the clock completes its current phases and then holds low with no strobe. It rises on the first clock edge after the condition clears.
- R6: When mode bit [13] is set, xfer_active is high, xfer_rd is 0 and fifo_empty is high, the clock completes its current phases and then holds low with no strobe. It rises on the first clock edge after the condition clears.
- R7: A FIFO flag has no effect on the clock if its proof bit is clear, if the transfer direction does not match, or if xfer_active is low.
- R8: A write with reg_sel=1 always sets the lock bit from reg_wdata[0]. While the lock bit is 1, a write with reg_sel=0 leaves the mode register unchanged.
- R9: A new ratio or a new power-save setting is sampled only at a rising edge. A change made during a high phase does not alter that phase or the low phase that follows it.
- R10: rise_stb is high for exactly the one cycle in which card_clk has just gone from low to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the lock register |
| reg_wdata | input | 14 | Write data |
| pwr_save | input | 1 | Power-saving request |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_rd | input | 1 | Transfer direction, 1 is read and 0 is write |
| fifo_full | input | 1 | Host FIFO cannot accept more read data |
| fifo_empty | input | 1 | Host FIFO has no write data |
| card_clk | output | 1 | Clock driven to the card |
| rise_stb | output | 1 | One-cycle pulse on each card-clock rising edge |
| mode_q | output | 14 | Current mode register contents |
| lock_q | output | 1 | Current lock bit |

## Verification
The bench measures high and low phase lengths for the smallest ratio, for odd and even ratios, for the largest ratio of 513, and for power-save factors including the largest shift. A wrong duty split, or an off-by-one in the count, shows up here as a phase that is one cycle long or short. Freeze tests hold each FIFO flag for many periods. They then require a clock that stays low and a prompt restart, which catches a stall that leaks pulses or never releases. Further tests apply each flag with its enable off, with the direction mismatched, and with no transfer active, which catches a freeze that is not gated. Reprogramming in the middle of a high phase checks that the phase being counted keeps its old length. A locked write checks that the mode register and the period both stay unchanged.

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int DIV_W = 8,
  parameter int PWS_W = 3,
  localparam int MODE_W = DIV_W + PWS_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [MODE_W-1:0] reg_wdata,
  input  logic              pwr_save,
  input  logic              xfer_active,
  input  logic              xfer_rd,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              card_clk,
  output logic              rise_stb,
  output logic [MODE_W-1:0] mode_q,
  output logic              lock_q
);

  localparam int N_W = DIV_W + 2;
  localparam int M_W = N_W + 2 ** PWS_W;

  localparam int ODD_B = DIV_W;
  localparam int PWS_L = DIV_W + 1;
  localparam int RDP_B = DIV_W + PWS_W + 1;
  localparam int WRP_B = DIV_W + PWS_W + 2;

  logic [N_W-1:0]   n_ratio;
  logic [M_W-1:0]   m_ratio, hi_next, lo_next;
  logic [M_W-1:0]   cnt, hi_len, lo_len;
  logic [PWS_W-1:0] pws;
  logic             stop, clk_q, stb_q;

  assign pws     = mode_q[PWS_L +: PWS_W];
  assign n_ratio = N_W'({mode_q[DIV_W-1:0], 1'b0}) + N_W'(mode_q[ODD_B]) + N_W'(2);
  assign m_ratio = pwr_save ? (M_W'(n_ratio) << pws) + M_W'(n_ratio) : M_W'(n_ratio);
  assign hi_next = m_ratio >> 1;
  assign lo_next = m_ratio - hi_next;

  assign stop = xfer_active & (xfer_rd ? (mode_q[RDP_B] & fifo_full)
                                       : (mode_q[WRP_B] & fifo_empty));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      lock_q <= 1'b0;
    end else if (reg_we) begin
      if (reg_sel)      lock_q <= reg_wdata[0];
      else if (!lock_q) mode_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      stb_q  <= 1'b0;
      cnt    <= '0;
      hi_len <= M_W'(1);
      lo_len <= M_W'(1);
    end else begin
      stb_q <= 1'b0;
      if (clk_q) begin
        if (cnt == hi_len - M_W'(1)) begin
          clk_q <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + M_W'(1);
        end
      end else if (cnt == lo_len - M_W'(1)) begin
        if (!stop) begin
          clk_q  <= 1'b1;
          stb_q  <= 1'b1;
          cnt    <= '0;
          hi_len <= hi_next;
          lo_len <= lo_next;
        end
      end else begin
        cnt <= cnt + M_W'(1);
      end
    end
  end

  assign card_clk = clk_q;
  assign rise_stb = stb_q;

endmodule

// File: rtl/card_clk_gen_checker.sv
module card_clk_gen_checker #(
  parameter int MW = 14,
  parameter int RDB = 12,
  parameter int WRB = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          reg_sel,
  input logic          xfer_active,
  input logic          xfer_rd,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          card_clk,
  input logic          rise_stb,
  input logic [MW-1:0] mode_q,
  input logic          lock_q
);

  logic rd_hold, wr_hold;
  assign rd_hold = xfer_active & xfer_rd & mode_q[RDB] & fifo_full;
  assign wr_hold = xfer_active & ~xfer_rd & mode_q[WRB] & fifo_empty;

  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (card_clk && !$past(card_clk))); // R10
  AST_EDGE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> rise_stb); // R10
  AST_LOCKED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel && lock_q) |=> $stable(mode_q)); // R8
  AST_RD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold && !card_clk) |=> !card_clk); // R5
  AST_WR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && !card_clk) |=> !card_clk); // R6

endmodule

bind card_clk_gen card_clk_gen_checker #(.MW(MODE_W), .RDB(RDP_B), .WRB(WRP_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .xfer_active(xfer_active), .xfer_rd(xfer_rd), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .card_clk(card_clk), .rise_stb(rise_stb),
  .mode_q(mode_q), .lock_q(lock_q)
);

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [13:0] reg_wdata = '0;
  logic pwr_save = 0, xfer_active = 0, xfer_rd = 0, fifo_full = 0, fifo_empty = 0;
  logic card_clk, rise_stb, lock_q;
  logic [13:0] mode_q;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pwr_save(pwr_save), .xfer_active(xfer_active), .xfer_rd(xfer_rd),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .card_clk(card_clk),
    .rise_stb(rise_stb), .mode_q(mode_q), .lock_q(lock_q)
  );

  function automatic logic [13:0] mk(int d, int p, int s, bit rd, bit wr);
    return {wr, rd, 3'(s), 1'(p), 8'(d)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(bit sel, logic [13:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic wait_rise(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (rise_stb) begin ok = 1; break; end
    end
  endtask

  task automatic measure(output int hi, output int lo);
    bit ok;
    hi = 0; lo = 0;
    wait_rise(ok);
    if (ok) wait_rise(ok);
    if (!ok) begin check(0, "R2 no rising strobe", 0, 1); return; end
    for (int i = 0; i < 70000; i++) begin
      if (card_clk) hi++; else lo++;
      step();
      if (rise_stb) break;
    end
  endtask

  task automatic t_period(int d, int p, int s, bit ps, string tag);
    int hi, lo, n, m;
    wr_reg(0, mk(d, p, s, 0, 0));
    pwr_save = ps;
    n = 2 * d + p + 2;
    m = ps ? n * ((1 << s) + 1) : n;
    measure(hi, lo);
    check(hi + lo == m, {tag, " period"}, hi + lo, m);
    check(hi == m / 2, "R3 high phase", hi, m / 2);
    check(lo == m - m / 2, "R3 low phase", lo, m - m / 2);
    pwr_save = 0;
  endtask

  task automatic t_reset();
    int hi, lo;
    check(mode_q == 0, "R1 mode after reset", int'(mode_q), 0);
    check(lock_q == 0, "R1 lock after reset", int'(lock_q), 0);
    check(card_clk == 0, "R1 clock low in reset", int'(card_clk), 0);
    rst_n = 1;
    step();
    check(rise_stb == 1, "R1 first strobe", int'(rise_stb), 1);
    measure(hi, lo);
    check(hi == 1 && lo == 1, "R1 default period", hi + lo, 2);
  endtask

  task automatic t_freeze(bit rd);
    int rises, highs;
    bit got;
    wr_reg(0, mk(1, 0, 0, rd, !rd));
    xfer_active = 1; xfer_rd = rd;
    if (rd) fifo_full = 1; else fifo_empty = 1;
    repeat (8) step();
    rises = 0; highs = 0;
    for (int i = 0; i < 30; i++) begin
      if (rise_stb) rises++;
      if (card_clk) highs++;
      step();
    end
    check(rises == 0, rd ? "R5 strobes while frozen" : "R6 strobes while frozen", rises, 0);
    check(highs == 0, rd ? "R5 clock high while frozen" : "R6 clock high while frozen", highs, 0);
    fifo_full = 0; fifo_empty = 0;
    step();
    got = rise_stb;
    check(got, rd ? "R5 restart strobe" : "R6 restart strobe", int'(got), 1);
    xfer_active = 0;
  endtask

  task automatic count_rises(output int r);
    r = 0;
    for (int i = 0; i < 40; i++) begin step(); if (rise_stb) r++; end
  endtask

  task automatic t_no_freeze();
    int r;
    wr_reg(0, mk(1, 0, 0, 1, 0));
    xfer_active = 1; xfer_rd = 0; fifo_full = 1;
    count_rises(r);
    check(r >= 9, "R7 direction mismatch", r, 10);
    wr_reg(0, mk(1, 0, 0, 0, 0));
    xfer_rd = 1;
    count_rises(r);
    check(r >= 9, "R7 read proof off", r, 10);
    wr_reg(0, mk(1, 0, 0, 1, 1));
    xfer_active = 0; fifo_empty = 1;
    count_rises(r);
    check(r >= 9, "R7 no transfer", r, 10);
    fifo_full = 0; fifo_empty = 0; xfer_rd = 0;
  endtask

  task automatic t_lock();
    int hi, lo;
    wr_reg(0, mk(2, 0, 0, 0, 0));
    wr_reg(1, 14'd1);
    check(lock_q == 1, "R8 lock set", int'(lock_q), 1);
    wr_reg(0, mk(7, 1, 0, 0, 0));
    check(mode_q == mk(2, 0, 0, 0, 0), "R8 locked write ignored", int'(mode_q), int'(mk(2, 0, 0, 0, 0)));
    measure(hi, lo);
    check(hi + lo == 6, "R8 period unchanged", hi + lo, 6);
    wr_reg(1, 14'd0);
    wr_reg(0, mk(7, 1, 0, 0, 0));
    check(mode_q == mk(7, 1, 0, 0, 0), "R8 unlocked write", int'(mode_q), int'(mk(7, 1, 0, 0, 0)));
  endtask

  task automatic t_midphase();
    int hi, lo;
    bit ok;
    wr_reg(0, mk(9, 0, 0, 0, 0));
    wait_rise(ok);
    wait_rise(ok);
    hi = 1; lo = 0;
    reg_we = 1; reg_sel = 0; reg_wdata = mk(0, 0, 0, 0, 0);
    pwr_save = 1;
    step();
    reg_we = 0;
    for (int i = 0; i < 100; i++) begin
      if (rise_stb) break;
      if (card_clk) hi++; else lo++;
      step();
    end
    pwr_save = 0;
    check(hi == 10, "R9 high phase kept", hi, 10);
    check(lo == 10, "R9 low phase kept", lo, 10);
    measure(hi, lo);
    check(hi + lo == 2, "R9 new ratio applied", hi + lo, 2);
  endtask

  task automatic t_strobe();
    int bad, n;
    logic prev;
    wr_reg(0, mk(0, 1, 0, 0, 0));
    step();
    prev = card_clk; bad = 0; n = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (rise_stb !== (card_clk && !prev)) bad++;
      if (rise_stb) n++;
      prev = card_clk;
    end
    check(bad == 0, "R10 strobe matches edge", bad, 0);
    check(n == 10, "R10 strobe count", n, 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    t_period(0, 1, 0, 0, "R2 ratio 3");
    t_period(5, 0, 0, 0, "R2 ratio 12");
    t_period(3, 1, 0, 0, "R2 ratio 9");
    t_period(255, 1, 0, 0, "R2 ratio 513");
    t_period(1, 0, 2, 1, "R4 ratio 4 shift 2");
    t_period(0, 1, 1, 1, "R4 ratio 3 shift 1");
    t_period(0, 0, 7, 1, "R4 ratio 2 shift 7");
    t_period(2, 0, 0, 1, "R4 ratio 6 shift 0");
    t_freeze(1);
    t_freeze(0);
    t_no_freeze();
    t_lock();
    t_midphase();
    t_strobe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule